// File: doc/BRIEF.md
# Fabric interrupt aggregation controller

This block collects interrupt requests from many on-chip peripherals and hands them to user logic as one output line per source. Each source passes through an enable bit that software sets through a small register port. Two banks exist: a wide bank A with 31 sources and a sparse bank B with only four implemented positions. Three of the bank A sources are not single wires. Each is an OR of a group of raw error lines: seven bus error-response lines, five cache error lines, and three memory-bridge events. The OR is taken before the enable gate.

A reason register shows which sources are currently asserted and enabled. It is a level view with no latching, so clearing must happen at the source. A one-bit mode register chooses which of two sets of direct request lines feeds the shared bank A positions. The composite positions are not affected by the mode.

The register port accepts a transfer in every cycle and has no back-pressure. A read returns its data after the next clock edge, and that data holds until the next read. The interrupt outputs are combinational from the sources and the registered enables.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: After reset, every enable bit and the mode bit are 0. Every interrupt output is 0 whatever the raw inputs are doing, and reads of both enable registers and the mode register return 0.
- R2: A write to address 0 (bank A enables) or address 1 (bank B enables) takes effect from the next clock edge. Each output then equals its raw source AND its enable bit, so writing 0 masks a source and writing 1 enables it.
- R3: Bank A implements bits 0 to 30. Bit 31 of the bank A enable register, the bank A reason register and `irq_a_o` always reads 0, even after a write of all ones.
- R4: Bank B implements only bits 3, 5, 6 and 7. These are fed by `aux_irq_i[0]`, `[1]`, `[2]` and `[3]` in that order. Every other bank B bit of the enable register, the reason register and `irq_b_o` reads 0.
- R5: Bank A bit 24 is the OR of the seven `bus_err_i` lines.
- R6: Bank A bit 27 is the OR of the five `cache_err_i` lines.
- R7: Bank A bit 25 is the OR of the three `bridge_evt_i` lines.
- R8: Address 4 holds the mode in bit 0, and bits 31:1 read 0. When the mode is 0, `direct_g0_i` feeds bank A; when it is 1, `direct_g1_i` does. The direct index k maps to position k for k up to 23, index 24 maps to position 26, and indices 25 to 27 map to positions 28 to 30.
- R9: Reason bits and outputs are level-sensitive. When a source drops, its output drops in the same cycle with no clock edge needed.
- R10: Writes to address 2 (bank A reason), address 3 (bank B reason) and addresses 5 to 7 change nothing. Reads of addresses 5 to 7 return 0.
- R11: A read with valid high and write low at an edge sets `reg_rdata_o` from that edge. The value stays unchanged until the next read, even if the register contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_valid_i | input | 1 | Register transfer request this cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Word address (0..4 mapped) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| direct_g0_i | input | 28 | Direct request lines, group 0 |
| direct_g1_i | input | 28 | Direct request lines, group 1 |
| bus_err_i | input | 7 | Bus error-response lines, one per master |
| cache_err_i | input | 5 | Cache error lines |
| bridge_evt_i | input | 3 | Memory-bridge events (error, disable-done, lock timeout) |
| aux_irq_i | input | 4 | Bank B request lines |
| irq_a_o | output | 32 | Bank A interrupt outputs |
| irq_b_o | output | 32 | Bank B interrupt outputs |

## Verification
The hardest cases to reach are where the mode setting interacts with the composite positions. In these cases a line from the unselected group or a single member of an OR group must show up, or stay hidden, at exactly one output bit. A table of vectors covers this. Each row rewrites the enable and mode registers and then drives one group with a single set bit while the other group is held all ones. Each row is checked at both the outputs and through a reason read. Directed steps follow for masking, reserved bits, ignored writes and the read-hold timing.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned AW          = 3;
  localparam int unsigned DIRECT_N    = 28;
  localparam int unsigned AUX_N       = 4;
  localparam int unsigned POS_BUSERR  = 24;
  localparam int unsigned POS_BRIDGE  = 25;
  localparam int unsigned POS_CACHE   = 27;
  localparam logic [DW-1:0] IMPL_A    = 32'h7FFF_FFFF;
  localparam logic [DW-1:0] IMPL_B    = 32'h0000_00E8;

  typedef enum logic [AW-1:0] {
    ADDR_EN_A   = 3'd0,
    ADDR_EN_B   = 3'd1,
    ADDR_RSN_A  = 3'd2,
    ADDR_RSN_B  = 3'd3,
    ADDR_MODE   = 3'd4
  } reg_addr_e;

  // Spread the direct lines over bank A, skipping the composite slots.
  function automatic logic [DW-1:0] place_direct(input logic [DIRECT_N-1:0] d);
    logic [DW-1:0] r;
    int unsigned k;
    r = '0;
    k = 0;
    for (int unsigned j = 0; j < DW-1; j++) begin
      if (j != POS_BUSERR && j != POS_BRIDGE && j != POS_CACHE) begin
        r[j] = d[k];
        k++;
      end
    end
    return r;
  endfunction

  // Spread the auxiliary lines over the implemented bank B bits, low first.
  function automatic logic [DW-1:0] place_aux(input logic [AUX_N-1:0] a);
    logic [DW-1:0] r;
    int unsigned k;
    r = '0;
    k = 0;
    for (int unsigned j = 0; j < DW; j++) begin
      if (IMPL_B[j] && k < AUX_N) begin
        r[j] = a[k];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_or_group.sv
module irq_or_group #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] lines_i,
  output logic         any_o
);
  assign any_o = |lines_i;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned     W    = 32,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] reason_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (wr_en_i) en_q <= wdata_i & IMPL;
  end

  assign enable_o = en_q;
  assign reason_o = raw_i & en_q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic          mode_wbit_i,
  input  logic [DW-1:0] en_a_i,
  input  logic [DW-1:0] en_b_i,
  input  logic [DW-1:0] rsn_a_i,
  input  logic [DW-1:0] rsn_b_i,
  output logic          wr_en_a_o,
  output logic          wr_en_b_o,
  output logic          mode_o,
  output logic [DW-1:0] rdata_o
);
  logic          mode_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rd_mux;
  logic          do_wr;
  logic          do_rd;

  assign do_wr     = valid_i &  write_i;
  assign do_rd     = valid_i & ~write_i;
  assign wr_en_a_o = do_wr && (addr_i == ADDR_EN_A);
  assign wr_en_b_o = do_wr && (addr_i == ADDR_EN_B);

  always_comb begin
    unique case (addr_i)
      ADDR_EN_A:  rd_mux = en_a_i;
      ADDR_EN_B:  rd_mux = en_b_i;
      ADDR_RSN_A: rd_mux = rsn_a_i;
      ADDR_RSN_B: rd_mux = rsn_b_i;
      ADDR_MODE:  rd_mux = {{(DW-1){1'b0}}, mode_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (do_wr && addr_i == ADDR_MODE) mode_q <= mode_wbit_i;
      if (do_rd) rdata_q <= rd_mux;
    end
  end

  assign mode_o  = mode_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_fanout_ctrl.sv
module irq_fanout_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned BUS_ERR_N = 7,
  parameter int unsigned CACHE_N   = 5,
  parameter int unsigned BRIDGE_N  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_valid_i,
  input  logic                 reg_write_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  input  logic [DIRECT_N-1:0]  direct_g0_i,
  input  logic [DIRECT_N-1:0]  direct_g1_i,
  input  logic [BUS_ERR_N-1:0] bus_err_i,
  input  logic [CACHE_N-1:0]   cache_err_i,
  input  logic [BRIDGE_N-1:0]  bridge_evt_i,
  input  logic [AUX_N-1:0]     aux_irq_i,
  output logic [DW-1:0]        irq_a_o,
  output logic [DW-1:0]        irq_b_o
);
  logic                busy_any, cache_any, bridge_any;
  logic                mode;
  logic                wr_a, wr_b;
  logic [DIRECT_N-1:0] direct_sel;
  logic [DW-1:0]       raw_a, raw_b;
  logic [DW-1:0]       en_a, en_b, rsn_a, rsn_b;

  irq_or_group #(.N(BUS_ERR_N)) u_or_bus (.lines_i(bus_err_i),    .any_o(busy_any));
  irq_or_group #(.N(CACHE_N))   u_or_cch (.lines_i(cache_err_i),  .any_o(cache_any));
  irq_or_group #(.N(BRIDGE_N))  u_or_brg (.lines_i(bridge_evt_i), .any_o(bridge_any));

  assign direct_sel = mode ? direct_g1_i : direct_g0_i;

  always_comb begin
    raw_a             = place_direct(direct_sel);
    raw_a[POS_BUSERR] = busy_any;
    raw_a[POS_BRIDGE] = bridge_any;
    raw_a[POS_CACHE]  = cache_any;
  end

  assign raw_b = place_aux(aux_irq_i);

  irq_mask_bank #(.W(DW), .IMPL(IMPL_A)) u_bank_a (
    .clk_i, .rst_ni, .wr_en_i(wr_a), .wdata_i(reg_wdata_i),
    .raw_i(raw_a), .enable_o(en_a), .reason_o(rsn_a)
  );

  irq_mask_bank #(.W(DW), .IMPL(IMPL_B)) u_bank_b (
    .clk_i, .rst_ni, .wr_en_i(wr_b), .wdata_i(reg_wdata_i),
    .raw_i(raw_b), .enable_o(en_b), .reason_o(rsn_b)
  );

  irq_reg_port u_regs (
    .clk_i, .rst_ni,
    .valid_i(reg_valid_i), .write_i(reg_write_i), .addr_i(reg_addr_i),
    .mode_wbit_i(reg_wdata_i[0]),
    .en_a_i(en_a), .en_b_i(en_b), .rsn_a_i(rsn_a), .rsn_b_i(rsn_b),
    .wr_en_a_o(wr_a), .wr_en_b_o(wr_b), .mode_o(mode), .rdata_o(reg_rdata_o)
  );

  assign irq_a_o = rsn_a;
  assign irq_b_o = rsn_b;
endmodule

// File: rtl/irq_fanout_ctrl_chk.sv
module irq_fanout_ctrl_chk
  import irq_agg_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_valid_i,
  input logic          reg_write_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic [6:0]    bus_err_i,
  input logic [4:0]    cache_err_i,
  input logic [2:0]    bridge_evt_i,
  input logic [DW-1:0] irq_a_o,
  input logic [DW-1:0] irq_b_o
);
  // R2
  mask_all_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && reg_write_i && reg_addr_i == 3'd0 && reg_wdata_i == '0) |=> (irq_a_o == '0));
  // R3
  top_bit_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_a_o[DW-1] == 1'b0);
  // R4
  sparse_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_b_o & ~IMPL_B) == '0);
  // R5
  bus_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_a_o[POS_BUSERR] |-> (bus_err_i != '0));
  // R6
  cache_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_a_o[POS_CACHE] |-> (cache_err_i != '0));
  // R7
  bridge_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_a_o[POS_BRIDGE] |-> (bridge_evt_i != '0));
  // R8
  mode_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !reg_write_i && reg_addr_i == 3'd4) |=> (reg_rdata_o[DW-1:1] == '0));
  // R10
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !reg_write_i && reg_addr_i > 3'd4) |=> (reg_rdata_o == '0));
  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_valid_i && !reg_write_i) |=> $stable(reg_rdata_o));
endmodule

bind irq_fanout_ctrl irq_fanout_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .bus_err_i(bus_err_i), .cache_err_i(cache_err_i), .bridge_evt_i(bridge_evt_i),
  .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
);

// File: tb/test_irq_fanout_ctrl.sv
module test_irq_fanout_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid_i = 1'b0, reg_write_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [27:0] direct_g0_i = '0, direct_g1_i = '0;
  logic [6:0]  bus_err_i = '0;
  logic [4:0]  cache_err_i = '0;
  logic [2:0]  bridge_evt_i = '0;
  logic [3:0]  aux_irq_i = '0;
  logic [31:0] irq_a_o, irq_b_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk_i = ~clk_i;

  irq_fanout_ctrl i_irq_fanout_ctrl (
    .clk_i, .rst_ni, .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .direct_g0_i, .direct_g1_i, .bus_err_i, .cache_err_i,
    .bridge_evt_i, .aux_irq_i, .irq_a_o, .irq_b_o
  );

  typedef struct packed {
    logic        mode;
    logic [31:0] en;
    logic [27:0] g0;
    logic [27:0] g1;
    logic [6:0]  bus;
    logic [4:0]  cch;
    logic [2:0]  brg;
    logic [31:0] exp;
  } vec_t;

  localparam logic [135:0] VECS [12] = '{
    {1'b0, 32'h7FFFFFFF, 28'h0,       28'hFFFFFFF, 7'h00, 5'h00, 3'h0, 32'h00000000},
    {1'b0, 32'h7FFFFFFF, 28'h0000001, 28'hFFFFFFF, 7'h00, 5'h00, 3'h0, 32'h00000001},
    {1'b1, 32'h7FFFFFFF, 28'h0000001, 28'h0,       7'h00, 5'h00, 3'h0, 32'h00000000},
    {1'b1, 32'h7FFFFFFF, 28'hFFFFFFF, 28'h1000000, 7'h00, 5'h00, 3'h0, 32'h04000000},
    {1'b0, 32'h7FFFFFFF, 28'h8000000, 28'h0,       7'h00, 5'h00, 3'h0, 32'h40000000},
    {1'b0, 32'h7FFFFFFF, 28'h0,       28'hFFFFFFF, 7'h40, 5'h00, 3'h0, 32'h01000000},
    {1'b0, 32'h7FFFFFFF, 28'h0,       28'h0,       7'h00, 5'h01, 3'h0, 32'h08000000},
    {1'b0, 32'h7FFFFFFF, 28'h0,       28'h0,       7'h00, 5'h00, 3'h4, 32'h02000000},
    {1'b0, 32'h7FFFFFFF, 28'hFFFFFFF, 28'h0,       7'h7F, 5'h1F, 3'h7, 32'h7FFFFFFF},
    {1'b0, 32'h00000F0F, 28'hFFFFFFF, 28'h0,       7'h00, 5'h00, 3'h0, 32'h00000F0F},
    {1'b0, 32'h0A000000, 28'hFFFFFFF, 28'h0,       7'h00, 5'h01, 3'h1, 32'h0A000000},
    {1'b1, 32'h7FFFFFFF, 28'hFFFFFFF, 28'h2000000, 7'h00, 5'h00, 3'h0, 32'h10000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = a;
    @(negedge clk_i);
    reg_valid_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    vec_t v;
    // Reset with every raw line high
    direct_g0_i = '1; direct_g1_i = '1; bus_err_i = '1; cache_err_i = '1;
    bridge_evt_i = '1; aux_irq_i = '1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 irq_a after reset", irq_a_o, 32'h0);
    check("R1 irq_b after reset", irq_b_o, 32'h0);
    reg_rd(3'd0, rd); check("R1 enable A reset", rd, 32'h0);
    reg_rd(3'd1, rd); check("R1 enable B reset", rd, 32'h0);
    reg_rd(3'd4, rd); check("R1 mode reset", rd, 32'h0);

    // Vector table
    for (int i = 0; i < 12; i++) begin
      v = VECS[i];
      reg_wr(3'd0, v.en);
      reg_wr(3'd4, {31'h0, v.mode});
      direct_g0_i = v.g0; direct_g1_i = v.g1; bus_err_i = v.bus;
      cache_err_i = v.cch; bridge_evt_i = v.brg;
      #1;
      check($sformatf("R8 R5 R6 R7 row %0d irq_a", i), irq_a_o, v.exp);
      reg_rd(3'd2, rd);
      check($sformatf("R2 row %0d reason A", i), rd, v.exp);
    end

    // R3 reserved top bit of bank A
    reg_wr(3'd0, 32'hFFFFFFFF);
    reg_rd(3'd0, rd); check("R3 enable A readback", rd, 32'h7FFFFFFF);
    reg_wr(3'd4, 32'hFFFFFFFF);
    reg_rd(3'd4, rd); check("R8 mode readback", rd, 32'h1);
    reg_wr(3'd4, 32'h0);

    // R4 sparse bank B
    reg_wr(3'd1, 32'hFFFFFFFF);
    reg_rd(3'd1, rd); check("R4 enable B readback", rd, 32'h000000E8);
    aux_irq_i = 4'hF; #1;
    check("R4 irq_b all", irq_b_o, 32'h000000E8);
    aux_irq_i = 4'b0001; #1;
    check("R4 aux0 to bit3", irq_b_o, 32'h00000008);
    aux_irq_i = 4'b1000; #1;
    check("R4 aux3 to bit7", irq_b_o, 32'h00000080);
    reg_rd(3'd3, rd); check("R4 reason B", rd, 32'h00000080);

    // R9 level behaviour without a clock edge
    direct_g0_i = '0; cache_err_i = '0; bridge_evt_i = '0;
    @(negedge clk_i);
    bus_err_i = 7'h01; #1;
    check("R9 bus source high", irq_a_o, 32'h01000000);
    bus_err_i = 7'h00; #1;
    check("R9 bus source drop", irq_a_o, 32'h0);

    // R10 ignored writes and unmapped reads
    reg_wr(3'd2, 32'h0);
    reg_wr(3'd3, 32'h0);
    reg_wr(3'd6, 32'h0);
    reg_rd(3'd0, rd); check("R10 enable A after ignored writes", rd, 32'h7FFFFFFF);
    reg_rd(3'd1, rd); check("R10 enable B after ignored writes", rd, 32'h000000E8);
    reg_rd(3'd6, rd); check("R10 unmapped read", rd, 32'h0);

    // R11 read data held until next read
    direct_g0_i = 28'h0000002;
    reg_rd(3'd2, rd); check("R11 read reason A", rd, 32'h00000002);
    direct_g0_i = 28'h0000004;
    repeat (2) @(negedge clk_i);
    check("R11 rdata held", reg_rdata_o, 32'h00000002);

    // R2 masking after writing zero
    direct_g0_i = '1;
    reg_wr(3'd0, 32'h0);
    check("R2 masked after zero write", irq_a_o, 32'h0);
    reg_wr(3'd1, 32'h0);
    check("R2 bank B masked", irq_b_o, 32'h0);

    finish_run();
  end
endmodule